// File: doc/BRIEF.md
# Multi-Width Integer Adder with Status Flags

This block is a registered integer adder. Each operation adds a destination operand and a source operand at an operand width chosen per operation (8, 16, 32 or 64 bits). It returns the truncated sum together with six arithmetic status flags: overflow, sign, zero, auxiliary carry, carry and parity. All six flags come from one shared datapath, whatever the width.

The source can be marked as a narrow immediate, either 8 or 32 bits wide. The block then sign-extends that immediate before the add. An execution stage feeds the block one operation per cycle through a valid strobe. It takes the result and flags from the output one clock later, qualified by an output valid strobe. The block has no state machine. The only sequential element is one output register stage, which loads when an operation is presented and otherwise holds.

Top module: `addflag_top`

## Requirements
- R1: When `in_valid` is 1, `result` one clock later equals `dst_op + src` truncated to the selected width. `width_sel` encodes the width as 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits.
- R2: Result bits at and above the selected width are output as 0.
- R3: With `src_is_imm` = 1, the source is sign-extended from `src_op[7:0]` (`imm_wide` = 0) or from `src_op[31:0]` (`imm_wide` = 1) before the add. With `src_is_imm` = 0, `src_op` is used as given.
- R4: `flag_cf` is the unsigned carry out of the top bit of the selected width.
- R5: `flag_of` is 1 exactly when the two operand sign bits at the selected width agree and the result sign bit differs from them.
- R6: `flag_sf` equals the top bit of the result at the selected width.
- R7: `flag_zf` is 1 only when every result bit within the selected width is 0.
- R8: `flag_af` is the carry from bit 3 into bit 4 of the add, for every width.
- R9: `flag_pf` is 1 when `result[7:0]` holds an even number of ones.
- R10: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 after a cycle with `in_valid` = 0.
- R11: A synchronous reset (`rst` = 1 at a rising edge) clears `out_valid`, `result` and all six flags.
- R12: In a cycle with `in_valid` = 0, `result` and all flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| width_sel | input | 2 | Operand width: 0=8, 1=16, 2=32, 3=64 bits |
| dst_op | input | 64 | Destination operand |
| src_op | input | 64 | Source operand or immediate |
| src_is_imm | input | 1 | Source is a narrow immediate to sign-extend |
| imm_wide | input | 1 | Immediate is 32 bits (1) or 8 bits (0) |
| out_valid | output | 1 | Result and flags valid |
| result | output | 64 | Sum, zero above the selected width |
| flag_of | output | 1 | Signed overflow |
| flag_sf | output | 1 | Sign |
| flag_zf | output | 1 | Zero |
| flag_af | output | 1 | Carry out of bit 3 |
| flag_cf | output | 1 | Unsigned carry |
| flag_pf | output | 1 | Even parity of the low result byte |

## Verification
Each result, every flag and `out_valid` is due exactly one rising edge after the operation is presented, because a single register lies between input and output. Reset takes effect at the first edge where `rst` is high. The bench drives every input on the falling edge and checks the outputs at the next falling edge, half a period after the register loads. The hold checks of R12 and the idle check of R10 are sampled one falling edge after a cycle with no operation.

// File: rtl/addflag_pkg.sv
package addflag_pkg;

    localparam int DATA_W = 64;
    localparam int IDX_W  = $clog2(DATA_W) + 1;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } width_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic cry;
        logic par;
    } flags_t;

    function automatic logic [IDX_W-1:0] width_bits(input width_e w);
        unique case (w)
            WID_8:   width_bits = IDX_W'(8);
            WID_16:  width_bits = IDX_W'(16);
            WID_32:  width_bits = IDX_W'(32);
            default: width_bits = IDX_W'(64);
        endcase
    endfunction

endpackage

// File: rtl/addflag_srcext.sv
module addflag_srcext #(
    parameter int DW       = 64,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 32
) (
    input  logic [DW-1:0] src_raw,
    input  logic          is_imm,
    input  logic          imm_wide,
    output logic [DW-1:0] src_ext
);

    localparam int NARROW_PAD = DW - NARROW_W;
    localparam int WIDE_PAD   = DW - WIDE_W;

    logic [DW-1:0] narrow_x;
    logic [DW-1:0] wide_x;

    assign narrow_x = {{NARROW_PAD{src_raw[NARROW_W-1]}}, src_raw[NARROW_W-1:0]};
    assign wide_x   = {{WIDE_PAD{src_raw[WIDE_W-1]}}, src_raw[WIDE_W-1:0]};

    always_comb begin
        if (!is_imm)
            src_ext = src_raw;
        else if (imm_wide)
            src_ext = wide_x;
        else
            src_ext = narrow_x;
    end

endmodule

// File: rtl/addflag_core.sv
module addflag_core
    import addflag_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  width_e        wsel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] sum_o,
    output flags_t        flags_o
);

    localparam int AUX_BIT = 4;
    localparam int PAR_W   = 8;

    logic [IDX_W-1:0] wb;
    logic [DW-1:0]    mask;
    logic [DW-1:0]    a_m;
    logic [DW-1:0]    b_m;
    logic [DW:0]      full;
    logic [DW-1:0]    res;
    logic             sa;
    logic             sb;
    logic             sr;

    always_comb begin
        wb    = width_bits(wsel);
        mask  = {DW{1'b1}} >> (IDX_W'(DW) - wb);
        a_m   = opa & mask;
        b_m   = opb & mask;
        full  = {1'b0, a_m} + {1'b0, b_m};
        res   = full[DW-1:0] & mask;
        sa    = a_m[wb - IDX_W'(1)];
        sb    = b_m[wb - IDX_W'(1)];
        sr    = res[wb - IDX_W'(1)];
        sum_o = res;
        flags_o.ovf = (sa == sb) && (sr != sa);
        flags_o.sgn = sr;
        flags_o.zro = (res == '0);
        flags_o.aux = a_m[AUX_BIT] ^ b_m[AUX_BIT] ^ full[AUX_BIT];
        flags_o.cry = full[wb];
        flags_o.par = ~^res[PAR_W-1:0];
    end

endmodule

// File: rtl/addflag_top.sv
module addflag_top
    import addflag_pkg::*;
#(
    parameter int IMM_NARROW_W = 8,
    parameter int IMM_WIDE_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        width_sel,
    input  logic [DATA_W-1:0] dst_op,
    input  logic [DATA_W-1:0] src_op,
    input  logic              src_is_imm,
    input  logic              imm_wide,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_of,
    output logic              flag_sf,
    output logic              flag_zf,
    output logic              flag_af,
    output logic              flag_cf,
    output logic              flag_pf
);

    logic [DATA_W-1:0] src_x;
    logic [DATA_W-1:0] sum_c;
    flags_t            flags_c;
    flags_t            flags_q;

    addflag_srcext #(
        .DW       (DATA_W),
        .NARROW_W (IMM_NARROW_W),
        .WIDE_W   (IMM_WIDE_W)
    ) u_srcext (
        .src_raw  (src_op),
        .is_imm   (src_is_imm),
        .imm_wide (imm_wide),
        .src_ext  (src_x)
    );

    addflag_core #(
        .DW (DATA_W)
    ) u_core (
        .wsel    (width_e'(width_sel)),
        .opa     (dst_op),
        .opb     (src_x),
        .sum_o   (sum_c),
        .flags_o (flags_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= sum_c;
                flags_q <= flags_c;
            end
        end
    end

    always_comb begin
        flag_of = flags_q.ovf;
        flag_sf = flags_q.sgn;
        flag_zf = flags_q.zro;
        flag_af = flags_q.aux;
        flag_cf = flags_q.cry;
        flag_pf = flags_q.par;
    end

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && flags_q == '0));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_upper_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && width_sel == WID_8) |=> (result[DATA_W-1:8] == '0));

    assert_sign_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && width_sel == WID_8) |=> (flag_sf == result[7]));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_zf == (result == '0)));

    assert_parity_flag_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_pf == ($countones(result[7:0]) % 2 == 0)));

    assert_hold_result_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

endmodule

// File: tb/tb_addflag_top.sv
module tb_addflag_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  width_sel;
    logic [63:0] dst_op;
    logic [63:0] src_op;
    logic        src_is_imm;
    logic        imm_wide;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_of, flag_sf, flag_zf, flag_af, flag_cf, flag_pf;

    int tests  = 0;
    int failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addflag_top dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .width_sel  (width_sel),
        .dst_op     (dst_op),
        .src_op     (src_op),
        .src_is_imm (src_is_imm),
        .imm_wide   (imm_wide),
        .out_valid  (out_valid),
        .result     (result),
        .flag_of    (flag_of),
        .flag_sf    (flag_sf),
        .flag_zf    (flag_zf),
        .flag_af    (flag_af),
        .flag_cf    (flag_cf),
        .flag_pf    (flag_pf)
    );

    // Reference: {result[63:0], of, sf, zf, af, cf, pf}
    function automatic logic [69:0] model(input logic [1:0] sel, input logic [63:0] d,
                                          input logic [63:0] s, input logic imm, input logic iw);
        int w;
        logic [63:0] mask, sx, a, b, r;
        logic [64:0] full;
        logic signed [65:0] sa, sb, ss, lim;
        logic o, af, pf, zf, sf, c;
        w  = 8 << sel;
        sx = s;
        if (imm) sx = iw ? {{32{s[31]}}, s[31:0]} : {{56{s[7]}}, s[7:0]};
        mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        a    = d & mask;
        b    = sx & mask;
        full = {1'b0, a} + {1'b0, b};
        r    = full[63:0] & mask;
        c    = full[w];
        sa   = $signed({2'b00, a} << (66 - w));
        sa   = sa >>> (66 - w);
        sb   = $signed({2'b00, b} << (66 - w));
        sb   = sb >>> (66 - w);
        ss   = sa + sb;
        lim  = 66'sd1 <<< (w - 1);
        o    = (ss >= lim) || (ss < -lim);
        af   = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        pf   = ($countones(r[7:0]) % 2) == 0;
        zf   = (r == 64'd0);
        sf   = r[w-1];
        return {r, o, sf, zf, af, c, pf};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input logic [69:0] e);
        chk("R1/R2/R3 result", result, e[69:6]);
        chk("R5 overflow", 64'(flag_of), 64'(e[5]));
        chk("R6 sign",     64'(flag_sf), 64'(e[4]));
        chk("R7 zero",     64'(flag_zf), 64'(e[3]));
        chk("R8 aux",      64'(flag_af), 64'(e[2]));
        chk("R4 carry",    64'(flag_cf), 64'(e[1]));
        chk("R9 parity",   64'(flag_pf), 64'(e[0]));
        chk("R10 valid",   64'(out_valid), 64'd1);
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic do_op(input logic [1:0] sel, input logic [63:0] d, input logic [63:0] s,
                         input logic imm, input logic iw);
        logic [69:0] e;
        e          = model(sel, d, s, imm, iw);
        in_valid   = 1'b1;
        width_sel  = sel;
        dst_op     = d;
        src_op     = s;
        src_is_imm = imm;
        imm_wide   = iw;
        @(negedge clk);
        in_valid   = 1'b0;
        check_all(e);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        failed++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin : stim
        logic [69:0] held;
        logic [63:0] held_res;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst = 1'b1; in_valid = 1'b0; width_sel = 2'd0;
        dst_op = '0; src_op = '0; src_is_imm = 1'b0; imm_wide = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 valid after reset",  64'(out_valid), 64'd0);
        chk("R11 result after reset", result, 64'd0);
        chk("R11 flags after reset",
            64'({flag_of, flag_sf, flag_zf, flag_af, flag_cf, flag_pf}), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corners
        do_op(2'd0, 64'h7F, 64'h01, 1'b0, 1'b0);                         // R5 R8 byte overflow
        do_op(2'd0, 64'hFF, 64'h01, 1'b0, 1'b0);                         // R4 R7 carry to zero
        do_op(2'd0, 64'hFFFF_FFFF_FFFF_FF80, 64'hABCD_0000_0000_0080, 1'b0, 1'b0); // R2 R5
        do_op(2'd1, 64'h8000, 64'h8000, 1'b0, 1'b0);                     // R4 R5 R7 word
        do_op(2'd2, 64'h0, 64'h80, 1'b1, 1'b0);                          // R3 imm8 negative
        do_op(2'd3, 64'h1, 64'h8000_0000, 1'b1, 1'b1);                   // R3 imm32 negative
        do_op(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0);         // R4 R7 64-bit wrap
        do_op(2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0);         // R5 R6 64-bit
        do_op(2'd1, 64'h0000_0000_0001_000F, 64'h7F, 1'b1, 1'b0);        // R3 R8 imm8 positive
        do_op(2'd0, 64'h03, 64'h00, 1'b0, 1'b0);                         // R9 parity even

        // R10 idle and R12 hold
        held     = {result, flag_of, flag_sf, flag_zf, flag_af, flag_cf, flag_pf};
        held_res = result;
        dst_op = 64'h1234; src_op = 64'h5678; width_sel = 2'd3;
        @(negedge clk);
        chk("R10 valid low when idle", 64'(out_valid), 64'd0);
        chk("R12 result held", result, held_res);
        chk("R12 flags held",
            64'({flag_of, flag_sf, flag_zf, flag_af, flag_cf, flag_pf}), 64'(held[5:0]));

        // Random stimulus
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [63:0] d, s;
            logic [1:0]  sel;
            d   = {$urandom, $urandom};
            s   = {$urandom, $urandom};
            sel = 2'($urandom % 4);
            if ($urandom % 8 == 0) s = -d;
            do_op(sel, d, s, 1'($urandom % 2), 1'($urandom % 2));
        end

        // R11 mid-run reset
        in_valid = 1'b1; dst_op = 64'hFF; src_op = 64'h1; width_sel = 2'd0;
        rst = 1'b1;
        @(negedge clk);
        chk("R11 mid-run valid",  64'(out_valid), 64'd0);
        chk("R11 mid-run result", result, 64'd0);
        chk("R11 mid-run flags",
            64'({flag_of, flag_sf, flag_zf, flag_af, flag_cf, flag_pf}), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule